// File: doc/BRIEF.md
# Display Regeneration Frame Pacer

This block sets the pace of a display-list fetch engine so that the picture on the screen is never redrawn faster than one frame period. The fetch engine strobes `startOrder` when it decodes the order that marks the top of a regeneration pass. The block then looks at its frame timer. If the timer has stopped, or is in the last cycle of its period, the timer restarts at once and fetching goes on. If the timer is still counting, the block raises `fetchStall` until the period ends. At that point the timer restarts and the stall drops by itself.

A display list that takes longer than one period to draw lets the timer stop before the next order arrives. Such a list runs at its own slower rate and never sees a stall. The frame length is `FRAME_CYCLES` clock cycles. At 250 MHz the default of 6,250,000 gives a 25 ms frame, which is a cap of 40 frames per second.

The same order opens the only window in which keyboard interrupts are let through. A request made at any other time is held and is delivered in the next window. Each timer restart also samples the light-pen switch.

Top module: `frame_pacer`

## Requirements
- R1: After reset all outputs are low and the timer is idle, so the first `startOrder` causes a `frameStart` pulse in the next cycle and no stall.
- R2: A `startOrder` that arrives while the timer runs and is not in its last count (count below FRAME_CYCLES-1) drives `fetchStall` high from the next cycle on.
- R3: While stalled, the timer restarts when its period completes. In that same cycle `fetchStall` falls and `frameStart` pulses, and the two restarts are exactly FRAME_CYCLES cycles apart.
- R4: A `startOrder` that arrives after the timer has stopped, or in the cycle its period completes, restarts the timer with no stall, and `frameStart` follows in the next cycle.
- R5: A `startOrder` strobe that arrives while `fetchStall` is high has no effect on when the stall ends.
- R6: `keyIrq` bit k can be high only in the cycle after a cycle in which `startOrder` or `fetchStall` was high. This window is the order being in execution.
- R7: A `keyReq` bit seen outside the window is held pending. It gives a one-cycle pulse on the same `keyIrq` bit in the cycle after the next window opens. Bit 0 is the alphanumeric keyboard and bit 1 is the function keyboard.
- R8: `penSample` pulses together with `frameStart` exactly when `penSwitch` was high in the cycle in which the restart was decided.
- R9: `frameStart` is a single-cycle pulse, and two pulses are never less than FRAME_CYCLES cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startOrder | input | 1 | One-cycle strobe: a start-timer order has been decoded |
| keyReq | input | KEYS | Raw keyboard interrupt requests (bit 0 alphanumeric, bit 1 function) |
| penSwitch | input | 1 | Light-pen switch level |
| fetchStall | output | 1 | Holds off storage fetches that follow the order |
| frameStart | output | 1 | One-cycle pulse on each timer restart |
| keyIrq | output | KEYS | Gated keyboard interrupts, one-cycle pulses |
| penSample | output | 1 | Pen switch seen closed at a timer restart |

## Verification
If the timer count is wrong, it shows at the ports within one frame: the stall ends early or late, and the spacing between `frameStart` pulses is off. A stuck wait state shows at once, because the stall outlives the FRAME_CYCLES bound and no restart pulse follows. Pending keyboard state that is lost or leaks out appears as an interrupt pulse that is missing or early, one cycle after the window opens or while the window is shut. The bench runs a reference model and compares all four outputs every cycle, so any of these faults is reported in the cycle where it first shows.

// File: rtl/frame_pacer_pkg.sv
package frame_pacer_pkg;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic restart;   // load count zero, mark timer running
    logic advance;   // step the count
    logic halt;      // period finished with no order waiting: timer idles
    logic window;    // order executing: keyboard interrupts may pass
  } pacerCtl_t;

endpackage

// File: rtl/frame_pacer_ctl.sv
module frame_pacer_ctl
  import frame_pacer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startOrder,
  input  logic      timerRunning,
  input  logic      periodDone,
  output pacerCtl_t ctl,
  output logic      stalled
);

  typedef enum logic {PASS, HOLD} pacerState_t;

  pacerState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      HOLD: begin
        // the order is still executing; further strobes are ignored
        ctl.window = 1'b1;
        if (periodDone) begin
          ctl.restart = 1'b1;
          stateNext   = PASS;
        end else begin
          ctl.advance = 1'b1;
        end
      end
      PASS: begin
        if (startOrder) begin
          ctl.window = 1'b1;
          if (!timerRunning || periodDone) begin
            ctl.restart = 1'b1;
          end else begin
            ctl.advance = 1'b1;
            stateNext   = HOLD;
          end
        end else if (timerRunning) begin
          if (periodDone) ctl.halt = 1'b1;
          else            ctl.advance = 1'b1;
        end
      end
      default: stateNext = PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PASS;
    else       state <= stateNext;
  end

  assign stalled = (state == HOLD);

endmodule

// File: rtl/frame_pacer_dp.sv
module frame_pacer_dp
  import frame_pacer_pkg::*;
#(
  parameter int FRAME_CYCLES = 6_250_000,
  parameter int KEYS         = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  pacerCtl_t       ctl,
  input  logic [KEYS-1:0] keyReq,
  input  logic            penSwitch,
  output logic            timerRunning,
  output logic            periodDone,
  output logic            frameStart,
  output logic            penSample,
  output logic [KEYS-1:0] keyIrq
);

  localparam int CNT_W = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] frameCount;

  assign periodDone = timerRunning && (frameCount == LAST_COUNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCount   <= '0;
      timerRunning <= 1'b0;
      frameStart   <= 1'b0;
      penSample    <= 1'b0;
    end else begin
      frameStart <= ctl.restart;
      penSample  <= ctl.restart && penSwitch;
      if (ctl.restart) begin
        frameCount   <= '0;
        timerRunning <= 1'b1;
      end else if (ctl.halt) begin
        timerRunning <= 1'b0;
      end else if (ctl.advance) begin
        frameCount <= frameCount + 1'b1;
      end
    end
  end

  // one pending bit per keyboard source
  for (genvar k = 0; k < KEYS; k++) begin : g_key
    logic keyPending;
    logic keyAvail;

    assign keyAvail = keyPending || keyReq[k];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        keyPending <= 1'b0;
        keyIrq[k]  <= 1'b0;
      end else if (ctl.window) begin
        keyPending <= 1'b0;
        keyIrq[k]  <= keyAvail;
      end else begin
        keyPending <= keyAvail;
        keyIrq[k]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/frame_pacer.sv
module frame_pacer
  import frame_pacer_pkg::*;
#(
  parameter int FRAME_CYCLES = 6_250_000,
  parameter int KEYS         = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startOrder,
  input  logic [KEYS-1:0] keyReq,
  input  logic            penSwitch,
  output logic            fetchStall,
  output logic            frameStart,
  output logic [KEYS-1:0] keyIrq,
  output logic            penSample
);

  pacerCtl_t ctl;
  logic      timerRunning;
  logic      periodDone;

  frame_pacer_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .startOrder   (startOrder),
    .timerRunning (timerRunning),
    .periodDone   (periodDone),
    .ctl          (ctl),
    .stalled      (fetchStall)
  );

  frame_pacer_dp #(
    .FRAME_CYCLES (FRAME_CYCLES),
    .KEYS         (KEYS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .keyReq       (keyReq),
    .penSwitch    (penSwitch),
    .timerRunning (timerRunning),
    .periodDone   (periodDone),
    .frameStart   (frameStart),
    .penSample    (penSample),
    .keyIrq       (keyIrq)
  );

endmodule

// File: rtl/frame_pacer_chk.sv
module frame_pacer_chk #(
  parameter int FRAME_CYCLES = 6_250_000,
  parameter int KEYS         = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            startOrder,
  input logic [KEYS-1:0] keyReq,
  input logic            penSwitch,
  input logic            fetchStall,
  input logic            frameStart,
  input logic [KEYS-1:0] keyIrq,
  input logic            penSample
);

  // cycles since the last frameStart, saturating at the period
  int   gap;
  logic seenFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap       <= 0;
      seenFrame <= 1'b0;
    end else if (frameStart) begin
      gap       <= 1;
      seenFrame <= 1'b1;
    end else if (gap < FRAME_CYCLES) begin
      gap <= gap + 1;
    end
  end

  assert_stall_needs_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchStall) |-> $past(startOrder));

  assert_release_restarts_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fetchStall) |-> frameStart);

  assert_restart_clears_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !fetchStall);

  assert_key_in_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|keyIrq) |-> $past(startOrder || fetchStall));

  assert_pen_on_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    penSample |-> frameStart);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  assert_min_spacing_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && seenFrame) |-> (gap >= FRAME_CYCLES));

endmodule

bind frame_pacer frame_pacer_chk #(
  .FRAME_CYCLES (FRAME_CYCLES),
  .KEYS         (KEYS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startOrder (startOrder),
  .keyReq     (keyReq),
  .penSwitch  (penSwitch),
  .fetchStall (fetchStall),
  .frameStart (frameStart),
  .keyIrq     (keyIrq),
  .penSample  (penSample)
);

// File: tb/test_frame_pacer.sv
module test_frame_pacer;

  localparam int FRAME = 16;
  localparam int KEYS  = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            startOrder = 1'b0;
  logic [KEYS-1:0] keyReq = '0;
  logic            penSwitch = 1'b0;
  logic            fetchStall;
  logic            frameStart;
  logic [KEYS-1:0] keyIrq;
  logic            penSample;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  frame_pacer #(.FRAME_CYCLES(FRAME), .KEYS(KEYS)) i_frame_pacer (
    .clk(clk), .rstN(rstN), .startOrder(startOrder), .keyReq(keyReq),
    .penSwitch(penSwitch), .fetchStall(fetchStall), .frameStart(frameStart),
    .keyIrq(keyIrq), .penSample(penSample)
  );

  // behavioural reference model
  bit mRun, mWait, mFs, mPen;
  int mCnt;
  bit [KEYS-1:0] mPend, mKey;

  always @(posedge clk) begin
    bit done, restart, win;
    if (!rstN) begin
      mRun = 0; mWait = 0; mFs = 0; mPen = 0; mCnt = 0; mPend = '0; mKey = '0;
    end else begin
      done = mRun && (mCnt == FRAME - 1);
      restart = 0;
      win = mWait || startOrder;
      if (mWait) begin
        if (done) begin restart = 1; mWait = 0; end
        else mCnt++;
      end else if (startOrder) begin
        if (!mRun || done) restart = 1;
        else begin mWait = 1; mCnt++; end
      end else if (mRun) begin
        if (done) mRun = 0;
        else mCnt++;
      end
      if (restart) begin mCnt = 0; mRun = 1; end
      mFs  = restart;
      mPen = restart && penSwitch;
      if (win) begin mKey = mPend | keyReq; mPend = '0; end
      else begin mPend = mPend | keyReq; mKey = '0; end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2/R3 fetchStall vs model", fetchStall, mWait);
      check("R9 frameStart vs model", frameStart, mFs);
      check("R6/R7 keyIrq vs model", keyIrq, mKey);
      check("R8 penSample vs model", penSample, mPen);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    startOrder = 1'b1;
    tick(1);
    startOrder = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int gapCount;
    tick(3);
    check("R1 reset stall", fetchStall, 0);
    check("R1 reset frameStart", frameStart, 0);
    check("R1 reset keyIrq", keyIrq, 0);
    rstN = 1'b1;
    tick(2);

    // first order after reset: no stall
    pulseStart();
    check("R1 first order frameStart", frameStart, 1);
    check("R1 first order no stall", fetchStall, 0);

    // order while running: stall, then released at period end
    gapCount = 0;
    tick(3); gapCount += 3;
    pulseStart(); gapCount += 1;
    check("R2 stall raised", fetchStall, 1);
    tick(2); gapCount += 2;
    startOrder = 1'b1; keyReq = 2'b10;   // R5 strobe and R6 key while stalled
    tick(1); gapCount += 1;
    startOrder = 1'b0; keyReq = '0;
    check("R6 key delivered in stall window", keyIrq, 2);
    while (!frameStart && gapCount < 100) begin tick(1); gapCount++; end
    check("R3 restart spacing", gapCount, FRAME);
    check("R3 stall released with restart", fetchStall, 0);
    check("R5 stray strobe ignored", gapCount, FRAME);

    // exact expiry: order in last count, no stall
    tick(FRAME - 1);
    penSwitch = 1'b1;
    pulseStart();
    penSwitch = 1'b0;
    check("R4 order at expiry restarts", frameStart, 1);
    check("R4 order at expiry no stall", fetchStall, 0);
    check("R8 pen sampled at restart", penSample, 1);

    // long display list: timer stops, key held pending
    tick(5);
    keyReq = 2'b01;
    tick(1);
    keyReq = '0;
    tick(1);
    check("R7 key held outside window", keyIrq, 0);
    tick(FRAME + 4);
    check("R7 still held", keyIrq, 0);
    pulseStart();
    check("R4 slow list no stall", fetchStall, 0);
    check("R4 slow list restart", frameStart, 1);
    check("R7 pending key delivered", keyIrq, 1);
    check("R8 no pen when switch open", penSample, 0);
    tick(1);
    check("R9 single-cycle frameStart", frameStart, 0);
    check("R7 pulse is one cycle", keyIrq, 0);

    // random traffic, checked against the model each cycle
    for (int i = 0; i < 600; i++) begin
      startOrder = ($urandom_range(0, 9) == 0);
      keyReq     = KEYS'($urandom_range(0, 15) == 0 ? $urandom_range(1, 3) : 0);
      penSwitch  = $urandom_range(0, 1);
      tick(1);
    end
    startOrder = 1'b0; keyReq = '0;
    tick(FRAME + 2);
    summary();
  end

endmodule